// File: doc/BRIEF.md
# Startup Configuration Select Controller

This block runs the power-up sequence of a clock-generator control core and decides which of four stored register sets is loaded into the working registers. After power-on reset is released it waits out a programmable reset interval. It then works out a configuration from a mode strap, which is captured while reset is held, from a stored flag and from two select pins. It asks the configuration store to load that set and reports the serial port as ready once the store answers.

When the strap was high and the stored flag is low, the select pins stay live once a startup window has passed. A change of exactly one pin starts a reload of the matching set, which is followed by a settle lockout. Each load start also issues a one-cycle output alignment reset, unless that reset is disabled. A change that flips both pins at once is reported and discarded. Pin changes that arrive inside the lockout are held back and applied when the lockout ends.

The load interface is a request/acknowledge pair. The store may hold off by keeping `load_done` low for any number of cycles, and `load_req` and `cfg_idx` stay constant until it answers.

Top module: `cfgsel_ctrl`

## Requirements
- R1: After `por_n` rises, `load_req` stays low for POR_CYCLES clock cycles. `port_ready` stays low until a load has been acknowledged by `load_done`.
- R2: With the strap high at reset, the first load uses `cfg_idx` = {`sel_pins[1]`,`sel_pins[0]`} (0..3, direct binary), `cfg_dflt` = 0 and `ser_en` = 0.
- R3: With the strap low at reset, `ser_en` = 1 and `cfg_idx` = 0. `cfg_dflt` = 1 when `cfg_flag` is 1 (serial default set) and 0 otherwise. Select pin changes have no effect on the configuration.
- R4: `load_req` stays high and `cfg_idx` holds until `load_done` is seen high.
- R5: A live pin change is acted on only when the strap was high, `cfg_flag` = 0, at least STARTUP_CYCLES have passed since reset and the first load has finished. Otherwise it is ignored.
- R6: A synchronized change of both pins in one cycle pulses `pin_err` for one cycle and leaves `cfg_idx` unchanged.
- R7: A single-pin change that arrives within SETTLE_CYCLES of the last accepted change is deferred and loaded when that window ends.
- R8: Each load start pulses `sync_rst` high for exactly one cycle when `sync_dis` = 0. It does not pulse at all when `sync_dis` = 1.
- R9: Once high, `port_ready` stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| sel_pins | input | 2 | Asynchronous configuration select pins |
| mode_strap | input | 1 | Mode strap, captured while reset is low |
| cfg_flag | input | 1 | Stored flag from the configuration store |
| sync_dis | input | 1 | 1 suppresses the alignment reset pulse |
| load_done | input | 1 | Store acknowledges the current load |
| cfg_idx | output | 2 | Index of the configuration to load |
| cfg_dflt | output | 1 | 1 selects the serial default register set |
| load_req | output | 1 | Load request to the store |
| ser_en | output | 1 | Serial interface register access enabled |
| port_ready | output | 1 | Serial port may respond |
| sync_rst | output | 1 | One-cycle output alignment reset |
| pin_err | output | 1 | One-cycle flag for an illegal two-pin change |

## Verification
A wrong sequencing state shows up at the ports as a missing or early `load_req`, or as a `port_ready` that rises without an acknowledge. Either is visible within a few cycles of the reset interval ending. A corrupted pending or lockout state shows up as a `cfg_idx` update that comes too early, too late or never. This is seen within one settle window of the pin edge, about four cycles after synchronization for an accepted change. Wrong strap capture shows up at once in `ser_en` and in the first index that is loaded.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } cfgsel_st_e;
endpackage

// File: rtl/cfgsel_sync.sv
module cfgsel_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_in[b];
        s2 <= s1;
      end
    end
    assign d_out[b] = s2;
  end
endmodule

// File: rtl/cfgsel_timer.sv
module cfgsel_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cfgsel_ctrl.sv
module cfgsel_ctrl #(
  parameter int POR_CYCLES     = 500000,
  parameter int STARTUP_CYCLES = 500000,
  parameter int SETTLE_CYCLES  = 50000
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic [cfgsel_pkg::SEL_W-1:0] sel_pins,
  input  logic                        mode_strap,
  input  logic                        cfg_flag,
  input  logic                        sync_dis,
  input  logic                        load_done,
  output logic [cfgsel_pkg::SEL_W-1:0] cfg_idx,
  output logic                        cfg_dflt,
  output logic                        load_req,
  output logic                        ser_en,
  output logic                        port_ready,
  output logic                        sync_rst,
  output logic                        pin_err
);
  import cfgsel_pkg::*;

  localparam int MAX_A  = (POR_CYCLES > STARTUP_CYCLES) ? POR_CYCLES : STARTUP_CYCLES;
  localparam int MAX_C  = (MAX_A > SETTLE_CYCLES) ? MAX_A : SETTLE_CYCLES;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  cfgsel_st_e st;
  logic             strap_q;
  logic [SEL_W-1:0] pins_s, prev, chg, pend;
  logic             pend_vld;
  logic             por_zero, win_zero, settle_zero;
  logic             live_ok, one_flip, two_flip, accept;

  cfgsel_sync #(.WIDTH(SEL_W)) u_sync (
    .clk(clk), .rst_n(por_n), .d_in(sel_pins), .d_out(pins_s)
  );

  cfgsel_timer #(.W(CNT_W), .RST_VAL(POR_CYCLES)) u_por_tmr (
    .clk(clk), .rst_n(por_n), .load(1'b0), .load_val('0), .expired(por_zero)
  );

  cfgsel_timer #(.W(CNT_W), .RST_VAL(STARTUP_CYCLES)) u_win_tmr (
    .clk(clk), .rst_n(por_n), .load(1'b0), .load_val('0), .expired(win_zero)
  );

  cfgsel_timer #(.W(CNT_W), .RST_VAL(0)) u_settle_tmr (
    .clk(clk), .rst_n(por_n), .load(accept), .load_val(CNT_W'(SETTLE_CYCLES)),
    .expired(settle_zero)
  );

  // edge classification on synchronized pins
  assign chg      = pins_s ^ prev;
  assign one_flip = ^chg;
  assign two_flip = &chg;
  assign live_ok  = strap_q & ~cfg_flag & win_zero & port_ready;
  assign accept   = (st == ST_RUN) & pend_vld & settle_zero;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st         <= ST_WAIT;
      strap_q    <= mode_strap;
      cfg_idx    <= '0;
      cfg_dflt   <= 1'b0;
      port_ready <= 1'b0;
      sync_rst   <= 1'b0;
      pin_err    <= 1'b0;
      pend       <= '0;
      pend_vld   <= 1'b0;
      prev       <= '0;
    end else begin
      sync_rst <= 1'b0;
      pin_err  <= live_ok & two_flip;
      prev     <= pins_s;

      case (st)
        ST_WAIT: begin
          if (por_zero) begin
            st       <= ST_LOAD;
            sync_rst <= ~sync_dis;
            if (strap_q) begin
              cfg_idx  <= pins_s;
              cfg_dflt <= 1'b0;
            end else begin
              cfg_idx  <= '0;
              cfg_dflt <= cfg_flag;
            end
          end
        end
        ST_LOAD: begin
          if (load_done) begin
            st         <= ST_RUN;
            port_ready <= 1'b1;
          end
        end
        ST_RUN: begin
          if (accept) begin
            st       <= ST_LOAD;
            cfg_idx  <= pend;
            sync_rst <= ~sync_dis;
          end
        end
        default: st <= ST_WAIT;
      endcase

      if (live_ok && one_flip) begin
        pend     <= pins_s;
        pend_vld <= 1'b1;
      end else if (accept) begin
        pend_vld <= 1'b0;
      end
    end
  end

  assign load_req = (st == ST_LOAD);
  assign ser_en   = ~strap_q;
endmodule

// File: rtl/cfgsel_ctrl_chk.sv
module cfgsel_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic [1:0] cfg_idx,
  input logic       cfg_dflt,
  input logic       load_req,
  input logic       load_done,
  input logic       ser_en,
  input logic       port_ready,
  input logic       sync_rst,
  input logic       sync_dis
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    (load_req && !load_done) |=> (load_req && $stable(cfg_idx)));

  assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
    port_ready |=> port_ready);

  assert_ready_after_ack_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(port_ready) |-> $past(load_done));

  assert_sync_single_R8: assert property (@(posedge clk) disable iff (!por_n)
    sync_rst |=> !sync_rst);

  assert_sync_masked_R8: assert property (@(posedge clk) disable iff (!por_n)
    sync_rst |-> !$past(sync_dis));

  assert_no_dflt_pin_mode_R2: assert property (@(posedge clk) disable iff (!por_n)
    !ser_en |-> !cfg_dflt);

  assert_serial_idx_fixed_R3: assert property (@(posedge clk) disable iff (!por_n)
    (ser_en && port_ready && $past(port_ready)) |-> $stable(cfg_idx));
endmodule

bind cfgsel_ctrl cfgsel_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .cfg_idx(cfg_idx), .cfg_dflt(cfg_dflt),
  .load_req(load_req), .load_done(load_done), .ser_en(ser_en),
  .port_ready(port_ready), .sync_rst(sync_rst), .sync_dis(sync_dis)
);

// File: tb/cfgsel_ctrl_tb_top.sv
module cfgsel_ctrl_tb_top;
  localparam int POR_C    = 20;
  localparam int WIN_C    = 80;
  localparam int SETTLE_C = 30;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic [1:0] sel_pins = 2'b00;
  logic       mode_strap = 1'b0;
  logic       cfg_flag = 1'b0;
  logic       sync_dis = 1'b0;
  logic       load_done = 1'b0;
  logic [1:0] cfg_idx;
  logic       cfg_dflt, load_req, ser_en, port_ready, sync_rst, pin_err;

  int total = 0;
  int bad = 0;
  int n_sync = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfgsel_ctrl #(.POR_CYCLES(POR_C), .STARTUP_CYCLES(WIN_C), .SETTLE_CYCLES(SETTLE_C)) dut_i (
    .clk(clk), .por_n(por_n), .sel_pins(sel_pins), .mode_strap(mode_strap),
    .cfg_flag(cfg_flag), .sync_dis(sync_dis), .load_done(load_done),
    .cfg_idx(cfg_idx), .cfg_dflt(cfg_dflt), .load_req(load_req), .ser_en(ser_en),
    .port_ready(port_ready), .sync_rst(sync_rst), .pin_err(pin_err)
  );

  // store model: acknowledge one cycle after a request
  always @(posedge clk) begin
    load_done <= load_req & ~load_done;
    if (sync_rst) n_sync <= n_sync + 1;
    if (pin_err)  n_err  <= n_err + 1;
  end

  // {strap, flag, pins[1:0], exp_idx[1:0], exp_dflt, exp_ser}
  localparam logic [7:0] VEC [8] = '{
    8'b1_0_00_00_0_0, 8'b1_0_01_01_0_0, 8'b1_1_10_10_0_0, 8'b1_0_11_11_0_0,
    8'b0_1_10_00_1_1, 8'b0_0_11_00_0_1, 8'b0_1_00_00_1_1, 8'b0_0_01_00_0_1
  };

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit strap, input bit flag, input logic [1:0] pins);
    @(negedge clk);
    por_n = 1'b0; mode_strap = strap; cfg_flag = flag; sel_pins = pins;
    wait_cyc(5);
    chk(port_ready == 1'b0, "R9 reset clears ready", int'(port_ready), 0);
    por_n = 1'b1;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0, e0;
    // table walk: startup selection
    for (int i = 0; i < 8; i++) begin
      do_reset(VEC[i][7], VEC[i][6], VEC[i][5:4]);
      s0 = n_sync;
      wait_cyc(10);
      chk(load_req == 1'b0, "R1 no early load", int'(load_req), 0);
      chk(port_ready == 1'b0, "R1 not ready early", int'(port_ready), 0);
      wait_cyc(30);
      chk(port_ready == 1'b1, "R1 ready after ack", int'(port_ready), 1);
      chk(cfg_idx == VEC[i][3:2], "R2/R3 startup index", int'(cfg_idx), int'(VEC[i][3:2]));
      chk(cfg_dflt == VEC[i][1], "R3 default select", int'(cfg_dflt), int'(VEC[i][1]));
      chk(ser_en == VEC[i][0], "R2/R3 serial enable", int'(ser_en), int'(VEC[i][0]));
      chk(n_sync - s0 == 1, "R8 one sync per load", n_sync - s0, 1);
    end

    // live reselection in pin mode
    do_reset(1'b1, 1'b0, 2'b00);
    wait_cyc(40);
    sel_pins = 2'b01;          // inside startup window: ignored
    wait_cyc(20);
    chk(cfg_idx == 2'd0, "R5 change before window ignored", int'(cfg_idx), 0);
    wait_cyc(40);
    s0 = n_sync;
    sel_pins = 2'b11;          // single flip, accepted
    wait_cyc(10);
    chk(cfg_idx == 2'd3, "R5 live change loaded", int'(cfg_idx), 3);
    chk(n_sync - s0 == 1, "R8 sync on live change", n_sync - s0, 1);
    sel_pins = 2'b10;          // inside lockout: deferred
    wait_cyc(10);
    chk(cfg_idx == 2'd3, "R7 change held in lockout", int'(cfg_idx), 3);
    wait_cyc(30);
    chk(cfg_idx == 2'd2, "R7 deferred change applied", int'(cfg_idx), 2);
    wait_cyc(40);
    e0 = n_err;
    sel_pins = 2'b01;          // both pins flip
    wait_cyc(10);
    chk(n_err - e0 == 1, "R6 error pulse", n_err - e0, 1);
    chk(cfg_idx == 2'd2, "R6 double change ignored", int'(cfg_idx), 2);
    wait_cyc(10);
    sync_dis = 1'b1;
    s0 = n_sync;
    sel_pins = 2'b00;
    wait_cyc(10);
    chk(cfg_idx == 2'd0, "R5 change after error", int'(cfg_idx), 0);
    chk(n_sync == s0, "R8 sync disabled", n_sync - s0, 0);
    sync_dis = 1'b0;
    wait_cyc(40);
    cfg_flag = 1'b1;
    sel_pins = 2'b01;
    wait_cyc(20);
    chk(cfg_idx == 2'd0, "R5 flag blocks change", int'(cfg_idx), 0);

    // serial mode: pins have no effect
    do_reset(1'b0, 1'b0, 2'b00);
    wait_cyc(100);
    sel_pins = 2'b10;
    wait_cyc(20);
    chk(cfg_idx == 2'd0, "R3 pins ignored in serial mode", int'(cfg_idx), 0);
    chk(port_ready == 1'b1, "R9 ready held", int'(port_ready), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule